// File: doc/BRIEF.md
# Scoreboard-Gated Warp Issue Selector

This block serves a single issue slot of a multi-warp in-order core. Several warps share the slot, and each has its own instruction buffer. The block looks at the head of every buffer, tests it against a scoreboard of register writes still in flight, and sends at most one hazard-free instruction per cycle towards the operand stage. The scoreboard keeps one busy bit per warp, per register type (integer or floating point) and per register index. It also records which functional-unit class owns each pending write.

The scan order rotates. A start pointer moves forward one place every clock cycle, whether or not anything issued, so no warp keeps the first turn for long. When the heads that are present are all blocked, the block charges the cycle to a total stall counter. Each conflicting register is also charged to the unit class that will write it.

Writeback returns a release request. The release is applied before the hazard check in the same cycle, so an instruction waiting on that register can issue on the cycle its producer retires.

Top module: `warp_issue_sel`

## Requirements
- R1: Local head k of this slot stands for global warp k*ISSUE_W + SLOT_IDX, and `iss_warp_o` reports that global number.
- R2: The scan starts at a pointer that is 0 after reset and advances by one, modulo the warps-per-slot count, on every clock edge, including cycles where nothing issues.
- R3: In scan order (pointer, pointer+1, ...) the first head that is valid and free of conflict is popped through a one-hot `hd_pop_o`. No other head is popped that cycle.
- R4: A head conflicts in either of two cases. (a) Its write-back flag is set and its destination is busy. (b) One of its valid sources is busy. Busy state is looked up per warp and per register type, where type 0 is integer and type 1 is floating point.
- R5: When a head with the write-back flag set issues, the scoreboard marks its destination busy and records its unit class as the owner. A release clears the busy bit.
- R6: A release and an issue in the same cycle see the state after the release, and the release comes first. A register can therefore be released and reserved again in one cycle, and a head reading it issues.
- R7: The total stall counter rises by one in each cycle where at least one head is valid, the operand stage is ready, and nothing issues.
- R8: Each conflicting register of a blocked head adds one to the counter of its owner's class. Class codes are 0 ALU, 1 FPU, 2 LSU and 3 SFU. Only heads scanned before the issued head are counted, or all valid heads when none issues. Two conflicts in one head add two.
- R9: An issue shows on `iss_valid_o` and `iss_warp_o` two clock edges after the cycle in which the head was popped.
- R10: While `opd_ready_i` is low, nothing is popped or issued and no counter changes. The pointer still advances.
- R11: Releasing a register that is not busy raises `sb_err_o` for the next cycle. Reserving a register that is already busy never happens.
- R12: All counters are CNT_W bits wide (64 by default) and saturate at all ones. Reset clears every counter, every busy bit and the issue pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_valid_i | input | WPS | Buffer of local warp k is non-empty |
| hd_wb_i | input | WPS | Head writes a destination register |
| hd_dtype_i | input | WPS | Destination register type (0 int, 1 fp) |
| hd_didx_i | input | WPS x RIDX_W | Destination register index |
| hd_sval_i | input | WPS x NSRC | Source operand valid flags |
| hd_stype_i | input | WPS x NSRC | Source register types |
| hd_sidx_i | input | WPS x NSRC x RIDX_W | Source register indices |
| hd_fu_i | input | WPS x 2 | Unit class of the head instruction |
| hd_pop_o | output | WPS | One-hot pop of the issued head |
| rel_valid_i | input | 1 | Writeback release request |
| rel_warp_i | input | LW | Local warp of the release |
| rel_type_i | input | 1 | Register type of the release |
| rel_idx_i | input | RIDX_W | Register index of the release |
| opd_ready_i | input | 1 | Operand stage accepts an issue |
| iss_valid_o | output | 1 | Issue presented to the operand stage |
| iss_warp_o | output | GW_W | Global warp number of the issue |
| stall_total_o | output | CNT_W | Cycles fully blocked by the scoreboard |
| stall_alu_o | output | CNT_W | Conflicts owned by ALU writes |
| stall_fpu_o | output | CNT_W | Conflicts owned by FPU writes |
| stall_lsu_o | output | CNT_W | Conflicts owned by LSU writes |
| stall_sfu_o | output | CNT_W | Conflicts owned by SFU writes |
| sb_err_o | output | 1 | Release of a register that was not busy |

## Verification
A busy bit stuck high or lost shows up at the pop outputs in the same cycle that a head names that register. A stuck bit blocks a head that should issue; a lost bit lets a dependent head through. A wrong owner class shows on a class counter one edge after the blocked cycle. A pointer that skips or stalls shows as the wrong one-hot pop whenever more than one head is eligible. A release ordered after the hazard check costs a cycle that a same-cycle release-and-read test catches at once. Pipeline depth errors appear on `iss_valid_o` exactly two edges after a pop.

// File: rtl/wis_pkg.sv
package wis_pkg;
  typedef enum logic [1:0] {
    FU_ALU = 2'd0,
    FU_FPU = 2'd1,
    FU_LSU = 2'd2,
    FU_SFU = 2'd3
  } fu_cls_e;

  localparam int unsigned NCLS   = 4;
  localparam int unsigned NRTYPE = 2;
  localparam int unsigned INC_W  = 8;
endpackage

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
  parameter int unsigned WPS    = 4,
  parameter int unsigned NREG   = 32,
  parameter int unsigned RIDX_W = 5,
  parameter int unsigned LW     = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                rel_valid_i,
  input  logic [LW-1:0]                       rel_warp_i,
  input  logic                                rel_type_i,
  input  logic [RIDX_W-1:0]                   rel_idx_i,
  input  logic                                res_valid_i,
  input  logic [LW-1:0]                       res_warp_i,
  input  logic                                res_type_i,
  input  logic [RIDX_W-1:0]                   res_idx_i,
  input  logic [1:0]                          res_cls_i,
  output logic [WPS-1:0][1:0][NREG-1:0]       busy_eff_o,
  output logic [WPS-1:0][1:0][NREG-1:0][1:0]  owner_o,
  output logic                                err_o
);
  logic [WPS-1:0][1:0][NREG-1:0]      busy_q;
  logic [WPS-1:0][1:0][NREG-1:0][1:0] owner_q;
  logic                               err_q;

  // release is applied before the hazard check
  always_comb begin
    busy_eff_o = busy_q;
    if (rel_valid_i) busy_eff_o[rel_warp_i][rel_type_i][rel_idx_i] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= '0;
      owner_q <= '0;
      err_q   <= 1'b0;
    end else begin
      busy_q <= busy_eff_o;
      if (res_valid_i) begin
        busy_q[res_warp_i][res_type_i][res_idx_i]  <= 1'b1;
        owner_q[res_warp_i][res_type_i][res_idx_i] <= res_cls_i;
      end
      err_q <= rel_valid_i && !busy_q[rel_warp_i][rel_type_i][rel_idx_i];
    end
  end

  assign owner_o = owner_q;
  assign err_o   = err_q;
endmodule

// File: rtl/wis_hazard.sv
module wis_hazard #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned RIDX_W = 5,
  parameter int unsigned NSRC   = 3,
  parameter int unsigned CW     = 3
) (
  input  logic [1:0][NREG-1:0]       busy_i,
  input  logic [1:0][NREG-1:0][1:0]  owner_i,
  input  logic                       wb_i,
  input  logic                       dtype_i,
  input  logic [RIDX_W-1:0]          didx_i,
  input  logic [NSRC-1:0]            sval_i,
  input  logic [NSRC-1:0]            stype_i,
  input  logic [NSRC-1:0][RIDX_W-1:0] sidx_i,
  output logic                       conflict_o,
  output logic [3:0][CW-1:0]         cls_cnt_o
);
  always_comb begin
    conflict_o = 1'b0;
    cls_cnt_o  = '0;
    if (wb_i && busy_i[dtype_i][didx_i]) begin
      conflict_o = 1'b1;
      cls_cnt_o[owner_i[dtype_i][didx_i]] = cls_cnt_o[owner_i[dtype_i][didx_i]] + CW'(1);
    end
    for (int j = 0; j < int'(NSRC); j++) begin
      if (sval_i[j] && busy_i[stype_i[j]][sidx_i[j]]) begin
        conflict_o = 1'b1;
        cls_cnt_o[owner_i[stype_i[j]][sidx_i[j]]] =
          cls_cnt_o[owner_i[stype_i[j]][sidx_i[j]]] + CW'(1);
      end
    end
  end
endmodule

// File: rtl/wis_pick.sv
module wis_pick #(
  parameter int unsigned WPS = 4,
  parameter int unsigned LW  = 2
) (
  input  logic [LW-1:0]  ptr_i,
  input  logic [WPS-1:0] valid_i,
  input  logic [WPS-1:0] elig_i,
  output logic [WPS-1:0] win_o,
  output logic [LW-1:0]  win_idx_o,
  output logic           any_o,
  output logic [WPS-1:0] charge_o
);
  always_comb begin
    int unsigned idx;
    win_o     = '0;
    win_idx_o = '0;
    any_o     = 1'b0;
    charge_o  = '0;
    for (int p = 0; p < int'(WPS); p++) begin
      idx = (int'(ptr_i) + p) % WPS;
      if (!any_o && elig_i[idx]) begin
        win_o[idx] = 1'b1;
        win_idx_o  = LW'(idx);
        any_o      = 1'b1;
      end else if (!any_o && valid_i[idx]) begin
        charge_o[idx] = 1'b1;   // blocked head scanned before any winner
      end
    end
  end
endmodule

// File: rtl/wis_satcnt.sv
module wis_satcnt #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] inc_i,
  output logic [W-1:0]  cnt_o
);
  localparam int unsigned SW = W + IW;
  logic [W-1:0]  cnt_q;
  logic [SW-1:0] sum;

  assign sum = SW'(cnt_q) + SW'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (sum > SW'({W{1'b1}}))      cnt_q <= '1;
    else                                cnt_q <= sum[W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/warp_issue_sel.sv
module warp_issue_sel #(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned ISSUE_W   = 2,
  parameter int unsigned SLOT_IDX  = 0,
  parameter int unsigned NREG      = 32,
  parameter int unsigned NSRC      = 3,
  parameter int unsigned CNT_W     = 64,
  localparam int unsigned WPS      = NUM_WARPS / ISSUE_W,
  localparam int unsigned LW       = (WPS > 1) ? $clog2(WPS) : 1,
  localparam int unsigned GW_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int unsigned RIDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [WPS-1:0]                   hd_valid_i,
  input  logic [WPS-1:0]                   hd_wb_i,
  input  logic [WPS-1:0]                   hd_dtype_i,
  input  logic [WPS-1:0][RIDX_W-1:0]       hd_didx_i,
  input  logic [WPS-1:0][NSRC-1:0]         hd_sval_i,
  input  logic [WPS-1:0][NSRC-1:0]         hd_stype_i,
  input  logic [WPS-1:0][NSRC-1:0][RIDX_W-1:0] hd_sidx_i,
  input  logic [WPS-1:0][1:0]              hd_fu_i,
  output logic [WPS-1:0]                   hd_pop_o,
  input  logic                             rel_valid_i,
  input  logic [LW-1:0]                    rel_warp_i,
  input  logic                             rel_type_i,
  input  logic [RIDX_W-1:0]                rel_idx_i,
  input  logic                             opd_ready_i,
  output logic                             iss_valid_o,
  output logic [GW_W-1:0]                  iss_warp_o,
  output logic [CNT_W-1:0]                 stall_total_o,
  output logic [CNT_W-1:0]                 stall_alu_o,
  output logic [CNT_W-1:0]                 stall_fpu_o,
  output logic [CNT_W-1:0]                 stall_lsu_o,
  output logic [CNT_W-1:0]                 stall_sfu_o,
  output logic                             sb_err_o
);
  import wis_pkg::*;

  localparam int unsigned CW   = $clog2(NSRC + 2);
  localparam int unsigned NCTR = NCLS + 1;

  logic [LW-1:0]                      ptr_q;
  logic [WPS-1:0][1:0][NREG-1:0]      busy_eff;
  logic [WPS-1:0][1:0][NREG-1:0][1:0] owner;
  logic [WPS-1:0]                     conflict;
  logic [WPS-1:0][3:0][CW-1:0]        cls_cnt;
  logic [WPS-1:0]                     elig, win, charge;
  logic [LW-1:0]                      win_idx;
  logic                               any_win;
  logic                               res_valid;
  logic                               res_type;
  logic [RIDX_W-1:0]                  res_idx;
  logic [1:0]                         res_cls;
  logic [NCTR-1:0][INC_W-1:0]         incs;
  logic [NCTR-1:0][CNT_W-1:0]         cnts;
  logic                               s1_v_q, s2_v_q;
  logic [GW_W-1:0]                    s1_w_q, s2_w_q, win_gw;

  // rotating start, advances every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ptr_q <= '0;
    else if (ptr_q == LW'(WPS - 1))   ptr_q <= '0;
    else                              ptr_q <= ptr_q + 1'b1;
  end

  wis_scoreboard #(.WPS(WPS), .NREG(NREG), .RIDX_W(RIDX_W), .LW(LW)) u_sb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rel_valid_i (rel_valid_i),
    .rel_warp_i  (rel_warp_i),
    .rel_type_i  (rel_type_i),
    .rel_idx_i   (rel_idx_i),
    .res_valid_i (res_valid),
    .res_warp_i  (win_idx),
    .res_type_i  (res_type),
    .res_idx_i   (res_idx),
    .res_cls_i   (res_cls),
    .busy_eff_o  (busy_eff),
    .owner_o     (owner),
    .err_o       (sb_err_o)
  );

  for (genvar k = 0; k < int'(WPS); k++) begin : g_haz
    wis_hazard #(.NREG(NREG), .RIDX_W(RIDX_W), .NSRC(NSRC), .CW(CW)) u_haz (
      .busy_i     (busy_eff[k]),
      .owner_i    (owner[k]),
      .wb_i       (hd_wb_i[k]),
      .dtype_i    (hd_dtype_i[k]),
      .didx_i     (hd_didx_i[k]),
      .sval_i     (hd_sval_i[k]),
      .stype_i    (hd_stype_i[k]),
      .sidx_i     (hd_sidx_i[k]),
      .conflict_o (conflict[k]),
      .cls_cnt_o  (cls_cnt[k])
    );
  end

  assign elig = hd_valid_i & ~conflict & {WPS{opd_ready_i}};

  wis_pick #(.WPS(WPS), .LW(LW)) u_pick (
    .ptr_i     (ptr_q),
    .valid_i   (hd_valid_i),
    .elig_i    (elig),
    .win_o     (win),
    .win_idx_o (win_idx),
    .any_o     (any_win),
    .charge_o  (charge)
  );

  assign hd_pop_o  = win;
  assign res_valid = any_win && hd_wb_i[win_idx];
  assign res_type  = hd_dtype_i[win_idx];
  assign res_idx   = hd_didx_i[win_idx];
  assign res_cls   = hd_fu_i[win_idx];
  assign win_gw    = GW_W'(int'(win_idx) * int'(ISSUE_W) + int'(SLOT_IDX));

  always_comb begin
    incs    = '0;
    incs[0] = INC_W'(opd_ready_i && (|hd_valid_i) && !any_win);
    for (int c = 0; c < int'(NCLS); c++) begin
      for (int k = 0; k < int'(WPS); k++) begin
        if (opd_ready_i && charge[k]) incs[c+1] = incs[c+1] + INC_W'(cls_cnt[k][c]);
      end
    end
  end

  for (genvar c = 0; c < int'(NCTR); c++) begin : g_ctr
    wis_satcnt #(.W(CNT_W), .IW(INC_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (incs[c]),
      .cnt_o  (cnts[c])
    );
  end

  assign stall_total_o = cnts[0];
  assign stall_alu_o   = cnts[1 + int'(FU_ALU)];
  assign stall_fpu_o   = cnts[1 + int'(FU_FPU)];
  assign stall_lsu_o   = cnts[1 + int'(FU_LSU)];
  assign stall_sfu_o   = cnts[1 + int'(FU_SFU)];

  // two-stage hand-off to the operand stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q <= 1'b0;
      s1_w_q <= '0;
      s2_v_q <= 1'b0;
      s2_w_q <= '0;
    end else begin
      s1_v_q <= any_win;
      s1_w_q <= win_gw;
      s2_v_q <= s1_v_q;
      s2_w_q <= s1_w_q;
    end
  end

  assign iss_valid_o = s2_v_q;
  assign iss_warp_o  = s2_w_q;
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int unsigned WPS    = 4,
  parameter int unsigned NREG   = 32,
  parameter int unsigned RIDX_W = 5,
  parameter int unsigned LW     = 2,
  parameter int unsigned CNT_W  = 64
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [WPS-1:0]                 hd_valid_i,
  input logic [WPS-1:0]                 hd_pop_o,
  input logic                           opd_ready_i,
  input logic                           iss_valid_o,
  input logic                           rel_valid_i,
  input logic                           sb_err_o,
  input logic [CNT_W-1:0]               stall_total_o,
  input logic [CNT_W-1:0]               stall_alu_o,
  input logic [WPS-1:0][1:0][NREG-1:0]  busy_eff,
  input logic                           res_valid,
  input logic [LW-1:0]                  win_idx,
  input logic                           res_type,
  input logic [RIDX_W-1:0]              res_idx
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst <= '0;
    else if (since_rst != 2'd3)  since_rst <= since_rst + 2'd1;
  end

  a_r3_pop_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hd_pop_o));

  a_r3_pop_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hd_pop_o & ~hd_valid_i) == '0);

  a_r10_no_pop_when_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opd_ready_i |-> hd_pop_o == '0);

  a_r9_issue_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst >= 2'd2 |-> iss_valid_o == $past(|hd_pop_o, 2));

  a_r7_total_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst >= 2'd1 |-> (stall_total_o == $past(stall_total_o)) ||
                          (stall_total_o == $past(stall_total_o) + 1'b1));

  a_r12_alu_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst >= 2'd1 |-> stall_alu_o >= $past(stall_alu_o));

  a_r11_err_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst >= 2'd1 && sb_err_o |-> $past(rel_valid_i));

  a_r11_no_double_reserve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid |-> !busy_eff[win_idx][res_type][res_idx]);
endmodule

bind warp_issue_sel wis_checker #(
  .WPS(WPS), .NREG(NREG), .RIDX_W(RIDX_W), .LW(LW), .CNT_W(CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hd_valid_i    (hd_valid_i),
  .hd_pop_o      (hd_pop_o),
  .opd_ready_i   (opd_ready_i),
  .iss_valid_o   (iss_valid_o),
  .rel_valid_i   (rel_valid_i),
  .sb_err_o      (sb_err_o),
  .stall_total_o (stall_total_o),
  .stall_alu_o   (stall_alu_o),
  .busy_eff      (busy_eff),
  .res_valid     (res_valid),
  .win_idx       (win_idx),
  .res_type      (res_type),
  .res_idx       (res_idx)
);

// File: tb/sim_warp_issue_sel.sv
module sim_warp_issue_sel;
  localparam int NW = 8, IWD = 2, SL = 1, NREG = 32, NSRC = 3, CW = 4;
  localparam int WPS = 4, LW = 2, GW = 3, RW = 5;
  localparam int SATV = 15;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic                         rst_n;
  logic [WPS-1:0]               hd_valid, hd_wb, hd_dtype, hd_pop;
  logic [WPS-1:0][RW-1:0]       hd_didx;
  logic [WPS-1:0][NSRC-1:0]     hd_sval, hd_stype;
  logic [WPS-1:0][NSRC-1:0][RW-1:0] hd_sidx;
  logic [WPS-1:0][1:0]          hd_fu;
  logic                         rel_valid, rel_type, ready;
  logic [LW-1:0]                rel_warp;
  logic [RW-1:0]                rel_idx;
  logic                         iss_valid, sb_err;
  logic [GW-1:0]                iss_warp;
  logic [CW-1:0]                c_tot, c_alu, c_fpu, c_lsu, c_sfu;

  warp_issue_sel #(.NUM_WARPS(NW), .ISSUE_W(IWD), .SLOT_IDX(SL), .NREG(NREG),
                   .NSRC(NSRC), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hd_valid_i(hd_valid), .hd_wb_i(hd_wb),
    .hd_dtype_i(hd_dtype), .hd_didx_i(hd_didx), .hd_sval_i(hd_sval),
    .hd_stype_i(hd_stype), .hd_sidx_i(hd_sidx), .hd_fu_i(hd_fu), .hd_pop_o(hd_pop),
    .rel_valid_i(rel_valid), .rel_warp_i(rel_warp), .rel_type_i(rel_type),
    .rel_idx_i(rel_idx), .opd_ready_i(ready), .iss_valid_o(iss_valid),
    .iss_warp_o(iss_warp), .stall_total_o(c_tot), .stall_alu_o(c_alu),
    .stall_fpu_o(c_fpu), .stall_lsu_o(c_lsu), .stall_sfu_o(c_sfu), .sb_err_o(sb_err)
  );

  // rotation model of R2
  int bptr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bptr <= 0;
    else        bptr <= (bptr + 1) % WPS;
  end

  int n_chk = 0, n_bad = 0;
  int e_tot = 0;
  int e_cls [4] = '{0, 0, 0, 0};
  bit done = 0;

  function automatic int sat(int x);
    return (x > SATV) ? SATV : x;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic clear_heads();
    hd_valid = '0; hd_wb = '0; hd_dtype = '0; hd_didx = '0;
    hd_sval = '0; hd_stype = '0; hd_sidx = '0; hd_fu = '0;
    rel_valid = 0; rel_warp = '0; rel_type = 0; rel_idx = '0; ready = 1;
  endtask

  task automatic head_rd(int k, logic t, int r);
    hd_valid[k] = 1; hd_sval[k][0] = 1; hd_stype[k][0] = t; hd_sidx[k][0] = RW'(r);
  endtask

  task automatic head_wr(int k, logic t, int r, int fu);
    hd_valid[k] = 1; hd_wb[k] = 1; hd_dtype[k] = t; hd_didx[k] = RW'(r); hd_fu[k] = 2'(fu);
  endtask

  task automatic check_counters(string tag);
    chk({tag, " R7 total"}, c_tot, sat(e_tot));
    chk({tag, " R8 alu"},   c_alu, sat(e_cls[0]));
    chk({tag, " R8 fpu"},   c_fpu, sat(e_cls[1]));
    chk({tag, " R8 lsu"},   c_lsu, sat(e_cls[2]));
    chk({tag, " R8 sfu"},   c_sfu, sat(e_cls[3]));
  endtask

  // warp k reserves int reg 10 with class k (0 ALU,1 FPU,2 LSU,3 SFU)
  task automatic setup_busy();
    for (int k = 0; k < WPS; k++) begin
      clear_heads();
      head_wr(k, 1'b0, 10, k);
      #1 chk("R5 reserve issue", hd_pop, 1 << k);
      @(negedge clk);
    end
    clear_heads();
  endtask

  // {start[1:0], valid[3:0], blocked[3:0], expected winner[2:0] (4 = none)}
  localparam logic [12:0] VEC [10] = '{
    {2'd0, 4'b1111, 4'b0000, 3'd0},
    {2'd1, 4'b1111, 4'b0000, 3'd1},
    {2'd3, 4'b1111, 4'b0000, 3'd3},
    {2'd2, 4'b0011, 4'b0000, 3'd0},
    {2'd0, 4'b1111, 4'b0011, 3'd2},
    {2'd3, 4'b1001, 4'b1000, 3'd0},
    {2'd1, 4'b1110, 4'b1110, 3'd4},
    {2'd2, 4'b0100, 4'b0000, 3'd2},
    {2'd0, 4'b0000, 4'b0000, 3'd4},
    {2'd1, 4'b1011, 4'b0010, 3'd3}
  };

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    clear_heads();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // reset state, R12
    check_counters("reset R12");
    chk("R9 reset iss_valid", iss_valid, 0);
    chk("R11 reset err", sb_err, 0);
    rst_n = 1;

    setup_busy();

    // table walk: R1 R2 R3 R4 R9
    for (int v = 0; v < 10; v++) begin
      logic [1:0] s;
      logic [3:0] vm, bm;
      logic [2:0] ex;
      bit found;
      {s, vm, bm, ex} = VEC[v];
      clear_heads();
      while (bptr != int'(s)) @(negedge clk);
      for (int k = 0; k < WPS; k++) if (vm[k]) head_rd(k, 1'b0, bm[k] ? 10 : 20);
      #1 chk($sformatf("R2 R3 vec%0d pop", v), hd_pop, (ex == 4) ? 0 : (1 << ex));
      found = 0;
      for (int p = 0; p < WPS; p++) begin
        int idx;
        idx = (int'(s) + p) % WPS;
        if (!found && vm[idx] && !bm[idx]) found = 1;
        else if (!found && vm[idx]) e_cls[idx]++;
      end
      if (vm != 0 && !found) e_tot++;
      @(negedge clk);
      clear_heads();
      @(negedge clk);
      chk($sformatf("R9 vec%0d iss_valid", v), iss_valid, (ex != 4) ? 1 : 0);
      if (ex != 4) chk($sformatf("R1 vec%0d iss_warp", v), iss_warp, ex * IWD + SL);
    end
    check_counters("table");

    // R4: register types are separate
    clear_heads();
    head_rd(0, 1'b1, 10);
    #1 chk("R4 fp type free", hd_pop, 1);
    @(negedge clk);

    // R4: destination busy blocks
    clear_heads();
    head_wr(0, 1'b0, 10, 0);
    #1 chk("R4 dst busy blocks", hd_pop, 0);
    @(negedge clk);
    e_tot++; e_cls[0]++;
    check_counters("dst");

    // R6: release and reserve in one cycle
    clear_heads();
    rel_valid = 1; rel_warp = 0; rel_type = 0; rel_idx = 10;
    head_wr(0, 1'b0, 10, 2);
    head_rd(0, 1'b0, 10);
    #1 chk("R6 release first", hd_pop, 1);
    @(negedge clk);
    clear_heads();
    head_rd(0, 1'b0, 10);
    #1 chk("R5 re-reserved busy", hd_pop, 0);
    @(negedge clk);
    e_tot++; e_cls[2]++;
    check_counters("R6 owner");

    // R11: release of a free register
    clear_heads();
    rel_valid = 1; rel_warp = 2; rel_type = 0; rel_idx = 5;
    @(negedge clk);
    chk("R11 bad release flag", sb_err, 1);
    clear_heads();
    rel_valid = 1; rel_warp = 1; rel_type = 0; rel_idx = 10;
    @(negedge clk);
    chk("R11 good release no flag", sb_err, 0);
    clear_heads();
    head_rd(1, 1'b0, 10);
    #1 chk("R5 release clears", hd_pop, 2);
    @(negedge clk);

    // R10: downstream not ready
    clear_heads();
    ready = 0;
    head_rd(1, 1'b0, 20);
    #1 chk("R10 no pop", hd_pop, 0);
    @(negedge clk);
    chk("R10 total held", c_tot, sat(e_tot));
    @(negedge clk);
    chk("R10 no issue", iss_valid, 0);

    // R8: two conflicts in one head
    clear_heads();
    hd_valid[3] = 1; hd_sval[3] = 3'b011;
    hd_sidx[3][0] = 10; hd_sidx[3][1] = 10;
    #1 chk("R8 multi blocked", hd_pop, 0);
    @(negedge clk);
    e_tot++; e_cls[3] += 2;
    check_counters("multi");

    // R12: saturation
    clear_heads();
    head_rd(2, 1'b0, 10);
    repeat (20) @(negedge clk);
    e_tot += 20; e_cls[2] += 20;
    chk("R12 total saturates", c_tot, SATV);
    chk("R12 lsu saturates", c_lsu, SATV);
    chk("R12 sfu unchanged", c_sfu, sat(e_cls[3]));

    // R12: reset clears counters and busy bits
    clear_heads();
    rst_n = 0;
    @(negedge clk);
    e_tot = 0; e_cls = '{0, 0, 0, 0};
    check_counters("reset2 R12");
    rst_n = 1;
    head_rd(2, 1'b0, 10);
    #1 chk("R12 busy cleared", hd_pop, 4);
    @(negedge clk);
    clear_heads();
    @(negedge clk);

    done = 1;
    report();
  end
endmodule